// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router takes the levels of eight shared PCI interrupt lines (lines 0..7) and places them onto 24 level-sensitive system interrupt outputs. Outputs 0..15 feed a legacy interrupt controller. Each of the eight lines has its own route register that names one legacy output, or parks the line off all legacy outputs. Several lines may share one legacy output, which is then the OR of all of them. At the same time, every line also drives its own dedicated output 16+k, and no two lines share one of these. A single ACPI system-control interrupt request (SCI) can be steered onto one of five outputs, or onto none, through a select code.

The block also holds the table that maps each device slot and interrupt pin to a shared line. Software tunes slots 25..31 through one 16-bit word per slot. Slot 30 is wired to a fixed map. Every other slot follows a built-in rotation that only uses lines 4..7. A registered lookup port returns the line for a given slot and pin.

Top module: `pci_irq_router`

## Requirements
- R1: After reset every route register has its disable bit (bit 7) set and its target field at 0, and the SCI select code is 0. All outputs read 0 in the first cycle after reset.
- R2: Legacy output n (0..15) is the OR of every enabled line whose route register has target field n. A route register is written at address k (0..7) for line k; bits 3:0 hold the target.
- R3: A line whose route register has bit 7 set contributes to no legacy output.
- R4: Output 16+k follows line k at all times, whatever its route register holds. The SCI is ORed onto it only when the SCI target is 16+k.
- R5: The SCI select code (address 8, bits 2:0) sends the SCI to an output as follows: code 0 to output 9, code 1 to 10, code 2 to 11, code 4 to 20, code 5 to 21.
- R6: Codes 3, 6 and 7 are reserved. While one of them is selected, the SCI drives no output.
- R7: When a select write changes the SCI target, the SCI is first withheld from every output for exactly one output cycle. It then appears on the new target. The old target drops before the new one rises.
- R8: Outputs are registered. A change on a line or on the SCI request shows on the outputs after the next rising clock edge.
- R9: For a slot outside 25..31, the lookup of pin p returns line ((slot+p) mod 4)+4.
- R10: Slot 30 always maps pin p to line 4+p. Writes to its word (address 21) are ignored.
- R11: Slots 25..29 and 31 are written at address 16+(slot-25). Pin p takes bits 4p+2..4p of the word. Each of these slots resets to the rotation of R9. The lookup result appears one cycle after the slot and pin are presented.
- R12: Bits 6:4 of a route register are ignored. Only bits 3:0 select the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| line_lvl | input | 8 | Levels of the shared PCI interrupt lines |
| sci_req | input | 1 | SCI request level |
| lk_slot | input | 5 | Device slot for the map lookup |
| lk_pin | input | 2 | Interrupt pin (0..3) for the map lookup |
| lk_line | output | 3 | Shared line mapped to the looked-up slot and pin |
| irq_out | output | 24 | Registered system interrupt outputs |

## Verification
The hardest case to reach from the ports is the retarget gap. The SCI must already be high when the select changes, and the outputs must be sampled in each of the three cycles that follow the write. Only then can the old line's drop, the empty cycle and the new line's rise be seen separately. The bench holds the SCI request high and then writes a new code. It samples once per cycle and checks the old and new outputs in each sample. It repeats this for a move to a reserved code and for a write that leaves the target unchanged, where no gap may appear.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  localparam int NUM_LINES     = 8;
  localparam int NUM_LEGACY    = 16;
  localparam int NUM_OUT       = NUM_LEGACY + NUM_LINES;
  localparam int TGT_W         = 4;
  localparam int DIS_BIT       = 7;
  localparam int OUT_IDX_W     = $clog2(NUM_OUT);
  localparam int LINE_IDX_W    = $clog2(NUM_LINES);
  localparam int NUM_PINS      = 4;
  localparam int PIN_FLD_W     = 3;
  localparam int PIN_SHIFT     = 4;
  localparam int CFG_FIRST     = 25;
  localparam int NUM_CFG       = 7;
  localparam int FIXED_SLOT    = 30;
  localparam int ADDR_W        = 5;
  localparam int DATA_W        = 16;
  localparam int ADDR_SCI      = 8;
  localparam int ADDR_SLOT     = 16;

  typedef struct packed {
    logic             off;
    logic [TGT_W-1:0] tgt;
  } route_t;

  typedef struct packed {
    logic                 vld;
    logic [OUT_IDX_W-1:0] idx;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [2:0] code);
    sci_tgt_t t;
    t.vld = 1'b1;
    case (code)
      3'd0: t.idx = OUT_IDX_W'(9);
      3'd1: t.idx = OUT_IDX_W'(10);
      3'd2: t.idx = OUT_IDX_W'(11);
      3'd4: t.idx = OUT_IDX_W'(20);
      3'd5: t.idx = OUT_IDX_W'(21);
      default: begin
        t.vld = 1'b0;
        t.idx = '0;
      end
    endcase
    return t;
  endfunction

  function automatic logic [LINE_IDX_W-1:0] rot_line(input int slot, input int pin);
    return LINE_IDX_W'(((slot + pin) % 4) + 4);
  endfunction
endpackage

// File: rtl/pci_irq_route_regs.sv
module pci_irq_route_regs
  import pci_irq_router_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output route_t [NUM_LINES-1:0]    routes,
  output sci_tgt_t                  sci_tgt,
  output logic                      sci_gap
);
  logic [2:0] sel_q;
  sci_tgt_t   new_tgt;

  assign new_tgt = sci_decode(wdata[2:0]);
  assign sci_tgt = sci_decode(sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_LINES; k++) begin
        routes[k].off <= 1'b1;
        routes[k].tgt <= '0;
      end
      sel_q   <= 3'd0;
      sci_gap <= 1'b0;
    end else begin
      sci_gap <= 1'b0;
      if (we && addr < ADDR_W'(NUM_LINES)) begin
        routes[addr[LINE_IDX_W-1:0]].off <= wdata[DIS_BIT];
        routes[addr[LINE_IDX_W-1:0]].tgt <= wdata[TGT_W-1:0];
      end
      if (we && addr == ADDR_W'(ADDR_SCI)) begin
        sel_q   <= wdata[2:0];
        sci_gap <= (new_tgt != sci_tgt);
      end
    end
  end

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= rst ? 1'b1 : seen_rst;

  // R1: reset leaves every route parked and the select at code 0
  p_reset_parked_r1: assert property (@(posedge clk)
    seen_rst && $past(rst) |-> (&{routes[0].off, routes[1].off, routes[2].off, routes[3].off,
                                  routes[4].off, routes[5].off, routes[6].off, routes[7].off})
                               && sci_tgt.vld && sci_tgt.idx == OUT_IDX_W'(9));
endmodule

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
  import pci_irq_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [4:0]            lk_slot,
  input  logic [1:0]            lk_pin,
  output logic [LINE_IDX_W-1:0] lk_line
);
  localparam int ROW_W = NUM_PINS * PIN_FLD_W;

  logic [ROW_W-1:0] rows [NUM_CFG];

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_slot
    if (CFG_FIRST + gi == FIXED_SLOT) begin : g_fixed
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign rows[gi][p*PIN_FLD_W +: PIN_FLD_W] = PIN_FLD_W'(4 + p);
      end
    end else begin : g_cfg
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int p = 0; p < NUM_PINS; p++)
            row_q[p*PIN_FLD_W +: PIN_FLD_W] <= rot_line(CFG_FIRST + gi, p);
        end else if (we && addr == ADDR_W'(ADDR_SLOT + gi)) begin
          for (int p = 0; p < NUM_PINS; p++)
            row_q[p*PIN_FLD_W +: PIN_FLD_W] <= wdata[p*PIN_SHIFT +: PIN_FLD_W];
        end
      end
      assign rows[gi] = row_q;
    end
  end

  logic [4:0]            rel;
  logic                  in_cfg;
  logic [LINE_IDX_W-1:0] pick;

  assign rel    = lk_slot - 5'(CFG_FIRST);
  assign in_cfg = (lk_slot >= 5'(CFG_FIRST)) && (rel < 5'(NUM_CFG));

  always_comb begin
    pick = LINE_IDX_W'(((lk_slot + 5'(lk_pin)) & 5'd3) + 5'd4);
    if (in_cfg) pick = rows[rel[2:0]][lk_pin*PIN_FLD_W +: PIN_FLD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) lk_line <= '0;
    else     lk_line <= pick;
  end

  // R10: the fixed slot always answers pin p with line 4+p
  p_fixed_slot_r10: assert property (@(posedge clk) disable iff (rst)
    lk_slot == 5'(FIXED_SLOT) |=> lk_line == LINE_IDX_W'(4 + $past(lk_pin)));
endmodule

// File: rtl/pci_irq_out_mux.sv
module pci_irq_out_mux
  import pci_irq_router_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   line_lvl,
  input  route_t [NUM_LINES-1:0] routes,
  input  logic                   sci_req,
  input  sci_tgt_t               sci_tgt,
  input  logic                   sci_gap,
  output logic [NUM_OUT-1:0]     irq_out
);
  logic              sci_on;
  logic [NUM_OUT-1:0] nxt;

  assign sci_on = sci_req && !sci_gap && sci_tgt.vld;

  for (genvar n = 0; n < NUM_LEGACY; n++) begin : g_leg
    logic [NUM_LINES-1:0] hit;
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_src
      assign hit[k] = line_lvl[k] && !routes[k].off && routes[k].tgt == TGT_W'(n);
    end
    assign nxt[n] = (|hit) || (sci_on && sci_tgt.idx == OUT_IDX_W'(n));
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_apic
    assign nxt[NUM_LEGACY+k] = line_lvl[k] || (sci_on && sci_tgt.idx == OUT_IDX_W'(NUM_LEGACY + k));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= nxt;
  end

  // R2: with no line and no SCI raised, every output falls next cycle
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    (line_lvl == '0 && !sci_req) |=> irq_out == '0);

  // R4: dedicated outputs copy their lines when the SCI sits on a legacy output
  p_dedicated_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!sci_tgt.vld || sci_tgt.idx < OUT_IDX_W'(NUM_LEGACY)) |=>
      irq_out[NUM_OUT-1:NUM_LEGACY] == $past(line_lvl));

  // R7: during the gap the SCI alone drives nothing
  p_gap_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (sci_gap && line_lvl == '0) |=> irq_out == '0);
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [NUM_LINES-1:0]  line_lvl,
  input  logic                  sci_req,
  input  logic [4:0]            lk_slot,
  input  logic [1:0]            lk_pin,
  output logic [LINE_IDX_W-1:0] lk_line,
  output logic [NUM_OUT-1:0]    irq_out
);
  route_t [NUM_LINES-1:0] routes;
  sci_tgt_t               sci_tgt;
  logic                   sci_gap;

  pci_irq_route_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .routes(routes), .sci_tgt(sci_tgt), .sci_gap(sci_gap)
  );

  pci_irq_swizzle u_swz (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
  );

  pci_irq_out_mux u_mux (
    .clk(clk), .rst(rst), .line_lvl(line_lvl), .routes(routes),
    .sci_req(sci_req), .sci_tgt(sci_tgt), .sci_gap(sci_gap), .irq_out(irq_out)
  );
endmodule

// File: tb/pci_irq_router_bench.sv
`timescale 1ns/1ps
module pci_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  line_lvl = '0;
  logic        sci_req = 1'b0;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_line;
  logic [23:0] irq_out;

  int errors = 0;
  int checks = 0;

  bit       m_off [8];
  bit [3:0] m_tgt [8];
  bit [2:0] m_sel;

  always #2 clk = ~clk;

  pci_irq_router u_pci_irq_router (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .line_lvl(line_lvl), .sci_req(sci_req), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_line(lk_line), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [7:0] l, input logic s);
    logic [23:0] g = '0;
    for (int k = 0; k < 8; k++) begin
      if (!m_off[k] && l[k]) g[m_tgt[k]] = 1'b1;
      if (l[k]) g[16+k] = 1'b1;
    end
    if (s) begin
      case (m_sel)
        3'd0: g[9]  = 1'b1;
        3'd1: g[10] = 1'b1;
        3'd2: g[11] = 1'b1;
        3'd4: g[20] = 1'b1;
        3'd5: g[21] = 1'b1;
        default: ;
      endcase
    end
    return g;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 5'd8) begin m_off[a[2:0]] = d[7]; m_tgt[a[2:0]] = d[3:0]; end
    if (a == 5'd8) m_sel = d[2:0];
  endtask

  task automatic drive(input logic [7:0] l, input logic s);
    @(negedge clk);
    line_lvl = l; sci_req = s;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic look(input int s, input int p, input int exp, input string req);
    @(negedge clk);
    lk_slot = 5'(s); lk_pin = 2'(p);
    @(negedge clk);
    chk(req, 32'(lk_line), 32'(exp));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin m_off[k] = 1'b1; m_tgt[k] = '0; end
    m_sel = 3'd0;
    chk("R1 outputs after reset", 32'(irq_out), 32'h0);
    drive(8'hFF, 1'b0);
    chk("R1 parked lines leave legacy outputs low", 32'(irq_out[15:0]), 32'h0);
    chk("R4 dedicated outputs follow lines", 32'(irq_out[23:16]), 32'hFF);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_routes;
    wr(5'd0, 16'h0005); wr(5'd1, 16'h0005); wr(5'd2, 16'h0007); wr(5'd6, 16'h000F);
    for (int l = 0; l < 8; l++) begin
      drive(8'(1 << l), 1'b0);
      chk("R2 single line", 32'(irq_out), 32'(model(8'(1 << l), 1'b0)));
    end
    drive(8'h03, 1'b0);
    chk("R2 shared output OR", 32'(irq_out), 32'(model(8'h03, 1'b0)));
    drive(8'h47, 1'b0);
    chk("R2 mixed lines", 32'(irq_out), 32'(model(8'h47, 1'b0)));
    wr(5'd1, 16'h0083);
    drive(8'h02, 1'b0);
    chk("R3 disabled line off legacy", 32'(irq_out[15:0]), 32'h0);
    chk("R4 disabled line keeps dedicated output", 32'(irq_out[23:16]), 32'h02);
    wr(5'd3, 16'h0074);
    drive(8'h08, 1'b0);
    chk("R12 upper route bits ignored", 32'(irq_out), 32'(model(8'h08, 1'b0)));
    chk("R12 target 4 high", 32'(irq_out[4]), 32'h1);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    line_lvl = 8'h01;
    #1 chk("R8 no change before clock edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R8 change after one edge", 32'(irq_out), 32'(model(8'h01, 1'b0)));
    line_lvl = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_sci_codes;
    for (int c = 0; c < 8; c++) begin
      wr(5'd8, 16'(c));
      drive(8'h00, 1'b1);
      if (c == 3 || c == 6 || c == 7)
        chk("R6 reserved code drives nothing", 32'(irq_out), 32'h0);
      else
        chk("R5 SCI target decode", 32'(irq_out), 32'(model(8'h00, 1'b1)));
      drive(8'h00, 1'b0);
    end
    wr(5'd8, 16'd5);
    drive(8'h20, 1'b1);
    chk("R4 SCI shares dedicated output 21", 32'(irq_out), 32'h200000);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_gap;
    wr(5'd8, 16'd0);
    drive(8'h00, 1'b1);
    chk("R7 SCI on 9 before move", 32'(irq_out), 32'h000200);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 16'd4; m_sel = 3'd4;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R7 old target holds in write cycle", 32'(irq_out), 32'h000200);
    @(negedge clk);
    chk("R7 gap cycle empty", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R7 new target 20 raised", 32'(irq_out), 32'h100000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 16'd4;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    chk("R7 same target write has no gap", 32'(irq_out), 32'h100000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 16'd6; m_sel = 3'd6;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 move to reserved drops SCI", 32'(irq_out), 32'h0);
    drive(8'h00, 1'b0);
  endtask

  task automatic t_swizzle;
    for (int p = 0; p < 4; p++) begin
      look(3, p, ((3 + p) % 4) + 4, "R9 rotation slot 3");
      look(30, p, 4 + p, "R10 fixed slot");
      look(26, p, ((26 + p) % 4) + 4, "R11 reset row slot 26");
    end
    look(0, 0, 4, "R9 rotation slot 0");
    look(24, 3, ((24 + 3) % 4) + 4, "R9 rotation slot 24");
    wr(5'd17, 16'h1370);
    look(26, 0, 0, "R11 slot 26 pin 0");
    look(26, 1, 7, "R11 slot 26 pin 1");
    look(26, 2, 3, "R11 slot 26 pin 2");
    look(26, 3, 1, "R11 slot 26 pin 3");
    wr(5'd22, 16'h0FFF);
    look(31, 2, 7, "R11 slot 31 written");
    wr(5'd21, 16'h0000);
    look(30, 1, 5, "R10 fixed slot write ignored");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_routes();
    t_latency();
    t_sci_codes();
    t_gap();
    t_swizzle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule